// File: doc/BRIEF.md
# ATA Task-File Buffer Command Engine

This block is the device side of an ATA-style register interface. A host reaches it through an 8-bit register port with a 3-bit offset. Offsets 1 to 6 hold the task-file parameters and offset 7 takes commands and returns status. Offset 0 is the data port, modelled as byte-wide accesses. A 512-byte sector buffer sits inside the block and is filled through a separate test write port. The READ BUFFER command hands that buffer to the host through the data port. It uses a busy phase, then a data-request phase, and raises an interrupt when the data becomes available.

The block also checks the ordering rule between long reads and long writes. A long read stores the address held in the head, cylinder and sector registers. A long write is accepted only if a long read to that exact address came before it. Every other case is aborted with an error. Media access is not modelled, so both long commands move no data. They only finish with the completion code in the sector-count register.

Top module: `ata_bufcmd`

## Requirements
- R1: After reset, status (offset 7), error (offset 1), sector count (offset 2) and drive/head (offset 6) all read 0x00, `irq` is low, and a data-port read (offset 0) returns 0x00.
- R2: Writes to offsets 2 to 6 read back unchanged. Offset 6 carries the LBA-mode flag in bit 6, the drive select in bit 4 and the head number (upper LBA bits) in bits 3:0.
- R3: Command 0xE4 (buffer readout) sets BSY (status bit 7) for PREP_CYC cycles. At the edge that ends the busy phase, BSY clears, DRQ (status bit 3) sets and `irq` rises, all together. BSY and DRQ are never set at the same time.
- R4: While DRQ is set, each offset-0 read strobe returns the next buffer byte, starting at byte 0. The bytes are the ones loaded through the test write port.
- R5: DRQ clears at the edge that consumes the 512th byte. After that, data-port reads return 0x00.
- R6: A status read (offset 7) clears `irq` at the next edge. If a command completes at that same edge, `irq` stays set.
- R7: Commands 0x22 and 0x23 (long read) complete without error and set the sector count to 0x00. They record the address formed from head bits 3:0, cylinder high, cylinder low and sector number.
- R8: Commands 0x32 and 0x33 (long write) complete without error, with sector count 0x00, when the recorded address matches the current registers. Repeated long writes to the same address keep succeeding.
- R9: A long write with no valid record, or with a different address, sets ERR (status bit 0), sets the error register to 0x04 (abort, bit 2) and sets the sector count to 0x01. A failed long write, or any command that is not a long command, discards the record.
- R10: Any other opcode finishes with ERR set and the error register at 0x04. The sector count is left unchanged.
- R11: A command written while BSY is set is ignored.
- R12: Accepting a command clears ERR and the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid while `reg_rd` is high |
| tw_en | input | 1 | Test write enable for the sector buffer |
| tw_addr | input | $clog2(BUF_BYTES) | Test write byte address |
| tw_data | input | 8 | Test write byte |
| irq | output | 1 | Pending interrupt |

## Verification
The end of a busy phase and a status read can fall on the same clock edge. The first sets the interrupt and the second clears it. The bench issues the readout command, then writes an opcode during the busy phase to confirm it is ignored. It then places a status strobe exactly on the completion edge. The strobe must return 0x80 with BSY still set, `irq` must still be high after that edge, and the next status read must return 0x08 and then clear `irq`.

// File: rtl/ata_pkg.sv
`timescale 1ns/1ps
package ata_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_ERR  = 3'd1;
  localparam logic [2:0] OFF_SC   = 3'd2;
  localparam logic [2:0] OFF_SN   = 3'd3;
  localparam logic [2:0] OFF_CL   = 3'd4;
  localparam logic [2:0] OFF_CH   = 3'd5;
  localparam logic [2:0] OFF_DH   = 3'd6;
  localparam logic [2:0] OFF_CMD  = 3'd7;

  localparam logic [7:0] OP_BUFREAD   = 8'hE4;
  localparam logic [6:0] OP_LRD_UPPER = 7'b0010001;
  localparam logic [6:0] OP_LWR_UPPER = 7'b0011001;

  localparam logic [7:0] ERRC_ABORT = 8'h04;
  localparam logic [7:0] SC_DONE_OK = 8'h00;
  localparam logic [7:0] SC_DONE_ER = 8'h01;

  typedef enum logic [1:0] {SQ_IDLE, SQ_BUSY, SQ_XFER} seq_t;
  typedef enum logic [1:0] {CK_BUFRD, CK_LRD, CK_LWR, CK_BAD} cmd_kind_t;

  typedef struct packed {
    logic [3:0] head;
    logic [7:0] cyl_hi;
    logic [7:0] cyl_lo;
    logic [7:0] sect;
  } blk_addr_t;

  function automatic cmd_kind_t classify(input logic [7:0] op);
    if (op == OP_BUFREAD)            return CK_BUFRD;
    else if (op[7:1] == OP_LRD_UPPER) return CK_LRD;
    else if (op[7:1] == OP_LWR_UPPER) return CK_LWR;
    else                              return CK_BAD;
  endfunction
endpackage

// File: rtl/ata_taskfile.sv
`timescale 1ns/1ps
module ata_taskfile
  import ata_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic          sc_load,
  input  logic [DW-1:0] sc_val,
  output logic [DW-1:0] sc,
  output logic [DW-1:0] sn,
  output logic [DW-1:0] cl,
  output logic [DW-1:0] ch,
  output logic [DW-1:0] dh,
  output blk_addr_t     cur_addr
);
  logic [DW-1:0] sc_q, sn_q, cl_q, ch_q, dh_q;
  logic [DW-1:0] sc_n, sn_n, cl_n, ch_n, dh_n;

  always_comb begin
    sc_n = sc_q; sn_n = sn_q; cl_n = cl_q; ch_n = ch_q; dh_n = dh_q;
    if (wr_en) begin
      case (wr_off)
        OFF_SC:  sc_n = wr_data;
        OFF_SN:  sn_n = wr_data;
        OFF_CL:  cl_n = wr_data;
        OFF_CH:  ch_n = wr_data;
        OFF_DH:  dh_n = wr_data;
        default: ;
      endcase
    end
    if (sc_load) sc_n = sc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0; sn_q <= '0; cl_q <= '0; ch_q <= '0; dh_q <= '0;
    end else begin
      sc_q <= sc_n; sn_q <= sn_n; cl_q <= cl_n; ch_q <= ch_n; dh_q <= dh_n;
    end
  end

  assign sc = sc_q;
  assign sn = sn_q;
  assign cl = cl_q;
  assign ch = ch_q;
  assign dh = dh_q;
  assign cur_addr = '{head: dh_q[3:0], cyl_hi: ch_q[7:0], cyl_lo: cl_q[7:0], sect: sn_q[7:0]};
endmodule

// File: rtl/ata_secbuf.sv
`timescale 1ns/1ps
module ata_secbuf #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ata_cmd_seq.sv
`timescale 1ns/1ps
module ata_cmd_seq
  import ata_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int PREP_CYC = 2,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = (PREP_CYC > 1) ? $clog2(PREP_CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_op,
  input  blk_addr_t     cur_addr,
  input  logic          data_rd,
  input  logic          stat_rd,
  output logic          bsy,
  output logic          drq,
  output logic          err,
  output logic          irq,
  output logic [7:0]    err_code,
  output logic [AW-1:0] rd_ptr,
  output logic          sc_load,
  output logic [7:0]    sc_val
);
  seq_t          st_q, st_n;
  cmd_kind_t     kind_q, kind_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          err_q, err_n, irq_q, irq_n, wlok_q, wlok_n;
  logic          rec_v_q, rec_v_n;
  blk_addr_t     rec_q, rec_n;
  logic [7:0]    ecode_q, ecode_n;
  logic          accept, done;
  cmd_kind_t     new_kind;

  assign accept   = cmd_wr && (st_q != SQ_BUSY);
  assign new_kind = classify(cmd_op);
  assign done     = (st_q == SQ_BUSY) && (cnt_q == '0);

  always_comb begin
    st_n = st_q; kind_n = kind_q; cnt_n = cnt_q; ptr_n = ptr_q;
    err_n = err_q; irq_n = irq_q; wlok_n = wlok_q;
    rec_v_n = rec_v_q; rec_n = rec_q; ecode_n = ecode_q;
    sc_load = 1'b0; sc_val = SC_DONE_OK;
    if (accept) begin
      st_n    = SQ_BUSY;
      cnt_n   = CW'(PREP_CYC - 1);
      kind_n  = new_kind;
      err_n   = 1'b0;
      ecode_n = '0;
      wlok_n  = rec_v_q && (rec_q == cur_addr);
      if (new_kind == CK_LRD) begin
        rec_v_n = 1'b1;
        rec_n   = cur_addr;
      end else if (new_kind != CK_LWR) begin
        rec_v_n = 1'b0;
      end
    end else if (st_q == SQ_BUSY) begin
      if (done) begin
        st_n = SQ_IDLE;
        case (kind_q)
          CK_BUFRD: begin st_n = SQ_XFER; ptr_n = '0; end
          CK_LRD:   begin sc_load = 1'b1; sc_val = SC_DONE_OK; end
          CK_LWR: begin
            sc_load = 1'b1;
            if (wlok_q) sc_val = SC_DONE_OK;
            else begin
              sc_val  = SC_DONE_ER;
              err_n   = 1'b1;
              ecode_n = ERRC_ABORT;
              rec_v_n = 1'b0;
            end
          end
          default: begin err_n = 1'b1; ecode_n = ERRC_ABORT; end
        endcase
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end else if (st_q == SQ_XFER && data_rd) begin
      ptr_n = ptr_q + 1'b1;
      if (ptr_q == AW'(DEPTH - 1)) st_n = SQ_IDLE;
    end
    if (stat_rd) irq_n = 1'b0;
    if (done)    irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; kind_q <= CK_BAD; cnt_q <= '0; ptr_q <= '0;
      err_q <= 1'b0; irq_q <= 1'b0; wlok_q <= 1'b0;
      rec_v_q <= 1'b0; rec_q <= '0; ecode_q <= '0;
    end else begin
      st_q <= st_n; kind_q <= kind_n; cnt_q <= cnt_n; ptr_q <= ptr_n;
      err_q <= err_n; irq_q <= irq_n; wlok_q <= wlok_n;
      rec_v_q <= rec_v_n; rec_q <= rec_n; ecode_q <= ecode_n;
    end
  end

  assign bsy      = (st_q == SQ_BUSY);
  assign drq      = (st_q == SQ_XFER);
  assign err      = err_q;
  assign irq      = irq_q;
  assign err_code = ecode_q;
  assign rd_ptr   = ptr_q;
endmodule

// File: rtl/ata_bufcmd.sv
`timescale 1ns/1ps
module ata_bufcmd
  import ata_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int PREP_CYC  = 2,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          tw_en,
  input  logic [AW-1:0] tw_addr,
  input  logic [7:0]    tw_data,
  output logic          irq
);
  logic [1:0]    rs_q;
  logic          rst_i_n;
  logic          bsy, drq, err;
  logic          cmd_wr, data_rd, stat_rd, sc_load;
  logic [7:0]    sc_val, err_code, buf_byte;
  logic [7:0]    sc, sn, cl, ch, dh;
  logic [AW-1:0] rd_ptr;
  blk_addr_t     cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign cmd_wr  = reg_wr && (reg_addr == OFF_CMD);
  assign stat_rd = reg_rd && (reg_addr == OFF_CMD);
  assign data_rd = reg_rd && (reg_addr == OFF_DATA) && drq;

  ata_taskfile #(.DW(8)) u_tf (
    .clk(clk), .rst_n(rst_i_n), .wr_en(reg_wr), .wr_off(reg_addr),
    .wr_data(reg_wdata), .sc_load(sc_load), .sc_val(sc_val),
    .sc(sc), .sn(sn), .cl(cl), .ch(ch), .dh(dh), .cur_addr(cur_addr)
  );

  ata_secbuf #(.DEPTH(BUF_BYTES), .DW(8)) u_buf (
    .clk(clk), .wr_en(tw_en), .wr_addr(tw_addr), .wr_data(tw_data),
    .rd_addr(rd_ptr), .rd_data(buf_byte)
  );

  ata_cmd_seq #(.DEPTH(BUF_BYTES), .PREP_CYC(PREP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .cmd_wr(cmd_wr), .cmd_op(reg_wdata),
    .cur_addr(cur_addr), .data_rd(data_rd), .stat_rd(stat_rd),
    .bsy(bsy), .drq(drq), .err(err), .irq(irq), .err_code(err_code),
    .rd_ptr(rd_ptr), .sc_load(sc_load), .sc_val(sc_val)
  );

  always_comb begin
    case (reg_addr)
      OFF_DATA: reg_rdata = drq ? buf_byte : 8'h00;
      OFF_ERR:  reg_rdata = err_code;
      OFF_SC:   reg_rdata = sc;
      OFF_SN:   reg_rdata = sn;
      OFF_CL:   reg_rdata = cl;
      OFF_CH:   reg_rdata = ch;
      OFF_DH:   reg_rdata = dh;
      default:  reg_rdata = {bsy, 3'b000, drq, 2'b00, err};
    endcase
  end
endmodule

// File: rtl/ata_bufcmd_chk.sv
`timescale 1ns/1ps
module ata_bufcmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic       bsy,
  input logic       drq,
  input logic       err
);
  a_r3_bsy_drq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

  a_r3_drq_after_bsy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> $past(bsy));

  a_r6_irq_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bsy));

  a_r6_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd7 && !bsy) |=> !irq);

  a_r5_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && !drq) |-> (reg_rdata == 8'h00));

  a_r9_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(bsy));
endmodule

bind ata_bufcmd ata_bufcmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .irq(irq), .bsy(bsy), .drq(drq), .err(err)
);

// File: tb/ata_bufcmd_bench.sv
`timescale 1ns/1ps
module ata_bufcmd_bench;
  localparam int BYTES = 512;
  localparam int PREP  = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       tw_en;
  logic [8:0] tw_addr;
  logic [7:0] tw_data;
  logic       irq;

  int n_vec  = 0;
  int n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  ata_bufcmd #(.BUF_BYTES(BYTES), .PREP_CYC(PREP)) u_ata_bufcmd (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data), .irq(irq)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) ^ (i >> 3));
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    step();
    reg_rd = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] e);
    n_vec++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, e);
    end
  endtask

  // monitor: pops one expectation per read strobe, mid-cycle
  always @(negedge clk) begin
    if (reg_rd === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_fail++;
        $display("FAIL scoreboard: read with no expectation, got %02h expected none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, reg_rdata, e);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_vec++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    tw_en = 1'b0; tw_addr = '0; tw_data = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(3'd7, 8'h00, "R1 status");
    rd(3'd1, 8'h00, "R1 error");
    rd(3'd2, 8'h00, "R1 sector count");
    rd(3'd6, 8'h00, "R1 drive/head");
    rd(3'd0, 8'h00, "R1 data idle");

    // R2 register readback
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd4, 8'hC3); wr(3'd5, 8'h96); wr(3'd6, 8'h5B);
    rd(3'd2, 8'hA5, "R2 sc"); rd(3'd3, 8'h3C, "R2 sn"); rd(3'd4, 8'hC3, "R2 cl");
    rd(3'd5, 8'h96, "R2 ch"); rd(3'd6, 8'h5B, "R2 dh");

    // preload buffer
    for (int i = 0; i < BYTES; i++) begin
      tw_en = 1'b1; tw_addr = 9'(i); tw_data = pat(i);
      step();
    end
    tw_en = 1'b0;

    // R3/R11/R6: readout command, ignored write while busy, status on completion edge
    wr(3'd7, 8'hE4);
    wr(3'd7, 8'h99);                    // R11 must be ignored
    rd(3'd7, 8'h80, "R3 busy phase");   // strobe lands on completion edge
    chk("R6 completion beats status clear", {7'b0, irq}, 8'h01);
    rd(3'd7, 8'h08, "R3 drq set / R11 ignored");
    chk("R6 status read clears irq", {7'b0, irq}, 8'h00);

    // R4 streaming
    for (int i = 0; i < BYTES; i++) rd(3'd0, pat(i), "R4 data byte");
    rd(3'd7, 8'h00, "R5 drq cleared after last byte");
    rd(3'd0, 8'h00, "R5 data after transfer");

    // R7 long read
    wr(3'd3, 8'h11); wr(3'd4, 8'h22); wr(3'd5, 8'h33); wr(3'd6, 8'h45); wr(3'd2, 8'h07);
    wr(3'd7, 8'h22); idle(PREP);
    chk("R7 irq", {7'b0, irq}, 8'h01);
    rd(3'd7, 8'h00, "R7 status");
    rd(3'd2, 8'h00, "R7 sc");
    rd(3'd1, 8'h00, "R7 error");

    // R8 long write, matching, then repeated
    wr(3'd7, 8'h33); idle(PREP);
    rd(3'd7, 8'h00, "R8 status"); rd(3'd2, 8'h00, "R8 sc");
    wr(3'd2, 8'h09); wr(3'd7, 8'h32); idle(PREP);
    rd(3'd7, 8'h00, "R8 repeat status"); rd(3'd2, 8'h00, "R8 repeat sc");

    // R9 mismatch, then record discarded
    wr(3'd3, 8'h12); wr(3'd7, 8'h33); idle(PREP);
    rd(3'd7, 8'h01, "R9 mismatch status"); rd(3'd1, 8'h04, "R9 error code");
    rd(3'd2, 8'h01, "R9 sc");
    wr(3'd3, 8'h11); wr(3'd7, 8'h33); idle(PREP);
    rd(3'd7, 8'h01, "R9 record dropped"); rd(3'd2, 8'h01, "R9 sc dropped");

    // R12 new command clears error
    wr(3'd7, 8'h23); idle(PREP);
    rd(3'd7, 8'h00, "R12 status"); rd(3'd1, 8'h00, "R12 error");

    // R10 unknown opcode
    wr(3'd2, 8'h05); wr(3'd7, 8'h99); idle(PREP);
    rd(3'd7, 8'h01, "R10 status"); rd(3'd1, 8'h04, "R10 error code");
    rd(3'd2, 8'h05, "R10 sc kept");

    // R9 other command discards record
    wr(3'd7, 8'h33); idle(PREP);
    rd(3'd7, 8'h01, "R9 after other cmd"); rd(3'd2, 8'h01, "R9 sc after other cmd");

    idle(2);
    finish_run();
  end
endmodule